// File: doc/BRIEF.md
# Accumulator Barrel Shift Unit

This block carries out the shift instructions of a fixed-point signal processor on one of its two 40-bit accumulators. The surrounding datapath presents the current contents of both accumulators together with a 16-bit instruction word and a valid strobe. One clock later the block returns the shifted 40-bit value, the accumulator it must be written to, and zero and sign flags taken from that value.

Three families of shift are decoded. The first shifts by a fixed 16 places. The second takes a 6-bit amount from the instruction word itself. The third takes a signed 16-bit amount from the middle word (bits 31:16) of an accumulator. In the last two families the sign of the amount can reverse the direction of the shift. A single barrel shifter serves every form. It runs in both directions and saturates counts of 40 or more.

Top module: `acc_shift_unit`

## Requirements
- R1: Opcode 1111 000r shifts accumulator r (bit 8) left by 16 and opcode 1111 010r shifts it right by 16 with zero fill. Opcode 1001 r001 (r in bit 11) shifts accumulator r right by 16 with sign fill. In each case the result goes back to accumulator r.
- R2: Opcode 0001 010r ttff ffff works on accumulator r (bit 8). tt in bits 7:6 chooses 00 logical left, 01 logical right, 10 arithmetic left and 11 arithmetic right. For both left kinds, the 6-bit field f is an unsigned count from 0 to 63.
- R3: For the two right kinds of R2, the count is minus the sign-extended f. f from 32 to 63 shifts right by 64 minus f (1 to 32). f from 1 to 31 reverses the direction and shifts left by f. f equal to 0 leaves the value unchanged.
- R4: Logical right shifts treat the accumulator as an unsigned 40-bit number and bring zeros in at bit 39. Arithmetic right shifts copy bit 39 into the vacated positions.
- R5: Opcodes 0x02CA and 0x02CB shift accumulator 0 by the signed middle word of accumulator 1. A positive amount shifts right: logical for 0x02CA, arithmetic for 0x02CB. A negative amount shifts left by its magnitude. Zero returns accumulator 0 unchanged. The result goes to accumulator 0.
- R6: Opcode 0011 110x 1100 0000 (bit 8 ignored) shifts accumulator 1 by the signed middle word of accumulator 0 with the opposite polarity. A positive amount shifts left, a negative one shifts logically right. The result always goes to accumulator 1.
- R7: Left shifts drop every bit pushed past bit 39. An effective count of 40 or more gives all zeros, or all copies of bit 39 for an arithmetic right shift. This includes the magnitude 32768.
- R8: flag_zero is high exactly when the 40-bit result is zero, and flag_sign equals bit 39 of the result. Both are presented in the same cycle as the result.
- R9: An instruction with op_valid high produces res_valid high on the next clock edge. With op_valid low, or with an opcode outside R1 to R6, res_valid stays low and res_value, res_dest and the flags keep their previous values.
- R10: A synchronous active-high rst clears res_valid, res_dest, res_value and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word present this cycle |
| opcode | input | 16 | Instruction word |
| acc0_in | input | 40 | Current contents of accumulator 0 |
| acc1_in | input | 40 | Current contents of accumulator 1 |
| res_valid | output | 1 | A shift result is presented |
| res_dest | output | 1 | Accumulator to write: 0 or 1 |
| res_value | output | 40 | Shifted accumulator value |
| flag_zero | output | 1 | Result equals zero |
| flag_sign | output | 1 | Bit 39 of the result |

## Verification
The checker assumes that op_valid, opcode and both accumulator inputs are at known levels on every clock edge after reset, and that the accumulator inputs are valid in the same cycle as the instruction they belong to. The bench drives every input only on the falling edge. It holds each input steady across the rising edge, and it keeps all inputs at defined values from time zero, also during reset. The random phase draws only fully defined 40-bit operands. It gives the middle word small positive and negative amounts, or the extremes, so that both directions and the saturation boundary are reached.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  localparam int ACC_W  = 40;
  localparam int MID_LO = 16;
  localparam int MID_W  = 16;
  localparam int OPC_W  = 16;
  localparam int IMM_W  = 6;
  localparam int CNT_W  = MID_W + 1;

  typedef struct packed {
    logic             hit;    // opcode is a shift
    logic             dest;   // accumulator written
    logic             src;    // accumulator shifted
    logic             left;   // direction
    logic             arith;  // sign fill on right shifts
    logic [CNT_W-1:0] cnt;    // magnitude of the shift
  } shift_cmd_t;

  // magnitude of a signed middle word, one bit wider so that -32768 fits
  function automatic logic [CNT_W-1:0] mid_mag(input logic [MID_W-1:0] m);
    logic [CNT_W-1:0] r;
    if (m[MID_W-1]) r = {1'b0, ~m} + 1'b1;
    else            r = {1'b0, m};
    return r;
  endfunction
endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [MID_W-1:0] mid0,
  input  logic [MID_W-1:0] mid1,
  output shift_cmd_t       cmd
);
  logic [IMM_W-1:0] fld;
  logic [IMM_W:0]   neg_fld;

  assign fld     = opcode[IMM_W-1:0];
  assign neg_fld = {1'b0, ~fld} + 1'b1;

  always_comb begin
    cmd = '0;
    casez (opcode)
      16'b1111_000?_????_????: begin
        cmd.hit = 1'b1; cmd.dest = opcode[8]; cmd.src = opcode[8];
        cmd.left = 1'b1; cmd.cnt = CNT_W'(16);
      end
      16'b1111_010?_????_????: begin
        cmd.hit = 1'b1; cmd.dest = opcode[8]; cmd.src = opcode[8];
        cmd.cnt = CNT_W'(16);
      end
      16'b1001_?001_????_????: begin
        cmd.hit = 1'b1; cmd.dest = opcode[11]; cmd.src = opcode[11];
        cmd.arith = 1'b1; cmd.cnt = CNT_W'(16);
      end
      16'b0001_010?_????_????: begin
        cmd.hit   = 1'b1; cmd.dest = opcode[8]; cmd.src = opcode[8];
        cmd.arith = opcode[7];
        if (!opcode[6]) begin
          cmd.left = 1'b1;
          cmd.cnt  = CNT_W'(fld);
        end else if (fld[IMM_W-1]) begin
          cmd.left = 1'b0;
          cmd.cnt  = CNT_W'(neg_fld);
        end else begin
          cmd.left = 1'b1;
          cmd.cnt  = CNT_W'(fld);
        end
      end
      16'b0000_0010_1100_101?: begin
        cmd.hit   = 1'b1; cmd.dest = 1'b0; cmd.src = 1'b0;
        cmd.arith = opcode[0];
        cmd.left  = mid1[MID_W-1];
        cmd.cnt   = mid_mag(mid1);
      end
      16'b0011_110?_1100_0000: begin
        cmd.hit  = 1'b1; cmd.dest = 1'b1; cmd.src = 1'b1;
        cmd.left = ~mid0[MID_W-1];
        cmd.cnt  = mid_mag(mid0);
      end
      default: cmd = '0;
    endcase
  end
endmodule

// File: rtl/acc_shift_barrel.sv
module acc_shift_barrel #(
  parameter int ACC_W = 40,
  parameter int CNT_W = 17
) (
  input  logic [ACC_W-1:0] value,
  input  logic             left,
  input  logic             arith,
  input  logic [CNT_W-1:0] cnt,
  output logic [ACC_W-1:0] result
);
  localparam int STG = $clog2(ACC_W);

  logic             fill;
  logic             sat;
  logic [ACC_W-1:0] stg [0:STG];

  assign fill   = arith & ~left & value[ACC_W-1];
  assign sat    = cnt >= CNT_W'(ACC_W);
  assign stg[0] = value;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [2*ACC_W-1:0] ext;
    assign ext        = {{ACC_W{fill}}, stg[k]} >> SH;
    assign stg[k+1]   = !cnt[k] ? stg[k] : (left ? (stg[k] << SH) : ext[ACC_W-1:0]);
  end

  assign result = sat ? {ACC_W{fill}} : stg[STG];
endmodule

// File: rtl/acc_shift_outreg.sv
module acc_shift_outreg #(
  parameter int ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dest,
  input  logic [ACC_W-1:0] value,
  output logic             res_valid,
  output logic             res_dest,
  output logic [ACC_W-1:0] res_value,
  output logic             flag_zero,
  output logic             flag_sign
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_dest  <= 1'b0;
      res_value <= '0;
      flag_zero <= 1'b0;
      flag_sign <= 1'b0;
    end else begin
      res_valid <= load;
      if (load) begin
        res_dest  <= dest;
        res_value <= value;
        flag_zero <= ~|value;
        flag_sign <= value[ACC_W-1];
      end
    end
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int W = ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic [W-1:0]     acc0_in,
  input  logic [W-1:0]     acc1_in,
  output logic             res_valid,
  output logic             res_dest,
  output logic [W-1:0]     res_value,
  output logic             flag_zero,
  output logic             flag_sign
);
  shift_cmd_t   cmd;
  logic [W-1:0] src_val;
  logic [W-1:0] shifted;

  acc_shift_decode u_dec (
    .opcode (opcode),
    .mid0   (acc0_in[MID_LO +: MID_W]),
    .mid1   (acc1_in[MID_LO +: MID_W]),
    .cmd    (cmd)
  );

  assign src_val = cmd.src ? acc1_in : acc0_in;

  acc_shift_barrel #(.ACC_W(W), .CNT_W(CNT_W)) u_bsh (
    .value  (src_val),
    .left   (cmd.left),
    .arith  (cmd.arith),
    .cnt    (cmd.cnt),
    .result (shifted)
  );

  acc_shift_outreg #(.ACC_W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (op_valid & cmd.hit),
    .dest      (cmd.dest),
    .value     (shifted),
    .res_valid (res_valid),
    .res_dest  (res_dest),
    .res_value (res_value),
    .flag_zero (flag_zero),
    .flag_sign (flag_sign)
  );
endmodule

// File: rtl/acc_shift_chk.sv
module acc_shift_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [15:0]  opcode,
  input logic [W-1:0] acc0_in,
  input logic [W-1:0] acc1_in,
  input logic         res_valid,
  input logic         res_dest,
  input logic [W-1:0] res_value,
  input logic         flag_zero,
  input logic         flag_sign
);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!res_valid && res_value == '0 && !flag_zero && !flag_sign));

  // R9
  valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(op_valid));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && $stable(res_value) && $stable(res_dest)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_zero == (res_value == '0)));

  // R8
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_sign == res_value[W-1]));

  // R5
  regshift_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode[15:1] == 15'h0165) |=> (res_valid && !res_dest));

  // R5
  zero_amount_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode[15:1] == 15'h0165 && acc1_in[31:16] == 16'h0)
      |=> (res_value == $past(acc0_in)));

  // R6
  reverse_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode[15:9] == 7'b0011110 && opcode[7:0] == 8'hC0)
      |=> (res_valid && res_dest));
endmodule

bind acc_shift_unit acc_shift_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .acc0_in   (acc0_in),
  .acc1_in   (acc1_in),
  .res_valid (res_valid),
  .res_dest  (res_dest),
  .res_value (res_value),
  .flag_zero (flag_zero),
  .flag_sign (flag_sign)
);

// File: tb/sim_acc_shift_unit.sv
`timescale 1ns/1ps
module sim_acc_shift_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic [39:0] acc0_in = '0;
  logic [39:0] acc1_in = '0;
  logic        res_valid, res_dest, flag_zero, flag_sign;
  logic [39:0] res_value;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic        q_valid[$];
  logic        q_dest[$];
  logic [39:0] q_val[$];
  string       q_tag[$];
  logic [39:0] last_val = '0;
  logic        last_dest = 1'b0;

  always #2.5 clk = ~clk;

  acc_shift_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .acc0_in(acc0_in), .acc1_in(acc1_in), .res_valid(res_valid),
    .res_dest(res_dest), .res_value(res_value), .flag_zero(flag_zero),
    .flag_sign(flag_sign)
  );

  function automatic logic [39:0] m_shl(input logic [39:0] v, input int n);
    if (n >= 40) return '0;
    return v << n;
  endfunction

  function automatic logic [39:0] m_lshr(input logic [39:0] v, input int n);
    if (n >= 40) return '0;
    return v >> n;
  endfunction

  function automatic logic [39:0] m_ashr(input logic [39:0] v, input int n);
    longint s;
    int m;
    s = longint'({{24{v[39]}}, v});
    m = (n > 39) ? 39 : n;
    return 40'(s >>> m);
  endfunction

  task automatic model(input logic [15:0] op, input logic [39:0] a0, input logic [39:0] a1,
                       output logic hit, output logic dst, output logic [39:0] r);
    logic [39:0] v;
    int n;
    hit = 1'b1; dst = 1'b0; r = '0;
    casez (op)
      16'b1111_000?_????_????: begin dst = op[8]; v = dst ? a1 : a0; r = m_shl(v, 16); end
      16'b1111_010?_????_????: begin dst = op[8]; v = dst ? a1 : a0; r = m_lshr(v, 16); end
      16'b1001_?001_????_????: begin dst = op[11]; v = dst ? a1 : a0; r = m_ashr(v, 16); end
      16'b0001_010?_????_????: begin
        dst = op[8]; v = dst ? a1 : a0;
        n = op[5] ? int'(op[5:0]) - 64 : int'(op[5:0]);
        if (!op[6]) r = m_shl(v, int'(op[5:0]));
        else if (n < 0) r = op[7] ? m_ashr(v, -n) : m_lshr(v, -n);
        else r = m_shl(v, n);
      end
      16'h02CA, 16'h02CB: begin
        dst = 1'b0;
        n = int'($signed(a1[31:16]));
        if (n > 0) r = op[0] ? m_ashr(a0, n) : m_lshr(a0, n);
        else if (n < 0) r = m_shl(a0, -n);
        else r = a0;
      end
      16'b0011_110?_1100_0000: begin
        dst = 1'b1;
        n = int'($signed(a0[31:16]));
        if (n > 0) r = m_shl(a1, n);
        else if (n < 0) r = m_lshr(a1, -n);
        else r = a1;
      end
      default: hit = 1'b0;
    endcase
  endtask

  task automatic fail_line(input string tag, input string what, input logic [39:0] act, input logic [39:0] exp);
    miscompares++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic check_out();
    logic ev, ed;
    logic [39:0] ex;
    string tg;
    if (q_valid.size() == 0) return;
    ev = q_valid.pop_front(); ed = q_dest.pop_front();
    ex = q_val.pop_front();   tg = q_tag.pop_front();
    vectors++;
    if (ev) begin
      if (res_valid !== 1'b1) fail_line(tg, "res_valid", 40'(res_valid), 40'd1);
      else if (res_dest !== ed) fail_line(tg, "res_dest", 40'(res_dest), 40'(ed));
      else if (res_value !== ex) fail_line(tg, "res_value", res_value, ex);
      else if (flag_zero !== (ex == '0)) fail_line({tg, " R8"}, "flag_zero", 40'(flag_zero), 40'(ex == '0));
      else if (flag_sign !== ex[39]) fail_line({tg, " R8"}, "flag_sign", 40'(flag_sign), 40'(ex[39]));
      last_val = ex; last_dest = ed;
    end else begin
      if (res_valid !== 1'b0) fail_line(tg, "res_valid", 40'(res_valid), 40'd0);
      else if (res_value !== last_val) fail_line(tg, "held res_value", res_value, last_val);
      else if (res_dest !== last_dest) fail_line(tg, "held res_dest", 40'(res_dest), 40'(last_dest));
    end
  endtask

  task automatic apply(input logic v, input logic [15:0] op, input logic [39:0] a0,
                       input logic [39:0] a1, input string tag);
    logic hit, dst;
    logic [39:0] r;
    @(negedge clk);
    check_out();
    op_valid = v; opcode = op; acc0_in = a0; acc1_in = a1;
    model(op, a0, a1, hit, dst, r);
    q_valid.push_back(v & hit); q_dest.push_back(dst);
    q_val.push_back(r); q_tag.push_back(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [39:0] ra, rb;
    logic [15:0] op;
    repeat (3) @(negedge clk);
    vectors++;  // R10 reset state
    if (res_valid !== 1'b0 || res_value !== '0 || flag_zero !== 1'b0 || flag_sign !== 1'b0 || res_dest !== 1'b0)
      fail_line("R10", "reset outputs", res_value, '0);
    rst = 1'b0;

    // R1 fixed shifts
    apply(1, 16'hF000, 40'h12_3456_789A, 40'h0, "R1 lsl16 ac0");
    apply(1, 16'hF100, 40'h0, 40'hFF_0000_1234, "R1 lsl16 ac1");
    apply(1, 16'hF400, 40'h80_1234_5678, 40'h0, "R1 R4 lsr16 zero fill");
    apply(1, 16'h9100, 40'h80_1234_5678, 40'h0, "R1 R4 asr16 sign fill");
    apply(1, 16'h9900, 40'h0, 40'hF0_0000_0000, "R1 asr16 ac1");
    // R2 immediate left forms
    apply(1, 16'h1405, 40'h00_0000_0001, 40'h0, "R2 lsl 5");
    apply(1, 16'h1427, 40'h00_0000_0003, 40'h0, "R2 R7 lsl 39 drop");
    apply(1, 16'h142D, 40'hFF_FFFF_FFFF, 40'h0, "R2 R7 lsl 45 zero");
    apply(1, 16'h1583, 40'h0, 40'h80_0000_0001, "R2 asl 3 ac1");
    // R3 immediate right forms
    apply(1, 16'h147F, 40'h80_0000_0002, 40'h0, "R3 R4 lsr f=3f");
    apply(1, 16'h1460, 40'hFF_0000_0000, 40'h0, "R3 lsr f=20 by 32");
    apply(1, 16'h14F8, 40'h90_0000_0000, 40'h0, "R3 R4 asr f=38 by 8");
    apply(1, 16'h14C4, 40'h90_0000_0001, 40'h0, "R3 asr f=04 left");
    apply(1, 16'h1440, 40'h55_5555_5555, 40'h0, "R3 lsr f=0");
    // R5 register-driven
    apply(1, 16'h02CA, 40'h80_0000_0000, 40'h00_0004_0000, "R5 lsrn right 4");
    apply(1, 16'h02CA, 40'h00_0000_0001, 40'h00_FFF8_0000, "R5 lsrn left 8");
    apply(1, 16'h02CA, 40'h12_3456_789A, 40'h00_0000_FFFF, "R5 lsrn zero");
    apply(1, 16'h02CB, 40'h80_0000_0000, 40'h00_0004_0000, "R5 asrn right 4");
    apply(1, 16'h02CB, 40'h80_0000_0000, 40'h00_0064_0000, "R5 R7 asrn 100");
    apply(1, 16'h02CA, 40'hFF_FFFF_FFFF, 40'h00_8000_0000, "R5 R7 lsrn -32768");
    apply(1, 16'h02CA, 40'h00_0000_0000, 40'h00_0000_0000, "R8 zero result");
    // R6 reversed polarity
    apply(1, 16'h3CC0, 40'h00_0003_0000, 40'h00_0000_0001, "R6 lsrnr left 3");
    apply(1, 16'h3DC0, 40'h00_FFFE_0000, 40'h80_0000_0000, "R6 lsrnr right 2");
    apply(1, 16'h3CC0, 40'h00_0000_0000, 40'h12_0000_0000, "R6 lsrnr zero");
    // R9 ignored stimulus
    apply(1, 16'h0000, 40'h11, 40'h22, "R9 unknown opcode");
    apply(1, 16'h3CC1, 40'h11, 40'h22, "R9 near-miss opcode");
    apply(0, 16'hF000, 40'h11, 40'h22, "R9 op_valid low");
    apply(1, 16'hF000, 40'h00_0000_0001, 40'h0, "R9 back to back 1");
    apply(1, 16'hF400, 40'h00_0000_0001, 40'h0, "R9 back to back 2");

    for (int i = 0; i < 600; i++) begin
      ra = {8'($urandom), 32'($urandom)};
      rb = {8'($urandom), 32'($urandom)};
      case ($urandom_range(0, 7))
        0: op = {7'b1111_000, 1'($urandom), 8'($urandom)};
        1: op = {7'b1111_010, 1'($urandom), 8'($urandom)};
        2: op = {4'b1001, 1'($urandom), 3'b001, 8'($urandom)};
        3, 4: op = {7'b0001_010, 1'($urandom), 8'($urandom)};
        5: op = {15'h0165, 1'($urandom)};
        6: op = {7'b0011_110, 1'($urandom), 8'hC0};
        default: op = 16'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: begin ra[31:16] = 16'($signed(6'($urandom))); rb[31:16] = 16'($signed(6'($urandom))); end
        1: begin ra[31:16] = 16'($urandom_range(0, 50)); rb[31:16] = 16'($urandom_range(0, 50)); end
        default: ;
      endcase
      apply(($urandom_range(0, 9) != 0), op, ra, rb, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    apply(0, 16'h0, 40'h0, 40'h0, "R9 drain");
    @(negedge clk);
    check_out();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule